// File: doc/BRIEF.md
# Programmable Reed-Solomon Encoder

This block is a streaming, systematic Reed-Solomon encoder over GF(256). Bytes arrive one per accepted transfer on a valid/ready input. A start-of-block flag marks the first byte of a block. When encoding is on, the K message bytes leave the block unchanged, one cycle after they are accepted. They are followed at once by 2t parity bytes, and the input is stalled while those parity bytes are produced.

The correction capability t (0 to 10) and the message length K are inputs that can change at run time. They are sampled only on the byte that opens a block. The generator coefficients for the sampled t are taken from a table that is computed when the design is elaborated. An enable level turns encoding off, and so do t = 0 or an illegal (t, K) pair. In each of these cases the block passes bytes through untouched and appends nothing. Decoding, interleaving and scrambling belong to neighbouring blocks.

Top module: `rs_stream_encoder`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1, also when the reset hits in the middle of a parity run.
- R2: The parity bytes are the remainder of m(x)·x^(2t) divided by g(x), where g(x) is the product of (x + α^i) for i = 0..2t-1. The arithmetic is in GF(256) with the reducing polynomial x^8+x^4+x^3+x^2+1 (0x11D), and α = 0x02. The first message byte is the highest-degree coefficient of m(x).
- R3: Every accepted byte appears on `out_data` with `out_valid`=1 and `out_par`=0 in the cycle after it is accepted, with its value unchanged.
- R4: A block opens on an accepted byte with `in_sob`=1 while no encoded block is in progress. `cfg_t`, `cfg_k` and `enc_en` are sampled on that byte only. Changing them later in the block has no effect on that block.
- R5: In an encoded block, exactly 2t bytes follow the K-th message byte with no gap. They are marked `out_par`=1 and come highest degree first.
- R6: `in_ready` is 0 for exactly the 2t cycles in which parity is produced, and 1 at all other times.
- R7: If `enc_en`=0 at block start, no parity is appended and `in_ready` stays 1.
- R8: If `cfg_t`=0 at block start, no parity is appended.
- R9: If `cfg_t` > 10, or `cfg_k` < 16, or `cfg_k` + 2·`cfg_t` > 255 at block start, the block is passed through with no parity.
- R10: `out_sob` is 1 only on the output copy of a byte that opened a block. An `in_sob` inside an encoded block is treated as a message byte, and bytes with `in_sob`=0 outside a block pass through without parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | 1 = encode blocks, 0 = bypass |
| cfg_t | input | 4 | Correction capability t, parity count 2t |
| cfg_k | input | 8 | Message length K in bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Input byte |
| in_sob | input | 1 | Input byte is the first of a block |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sob | output | 1 | Output byte opened a block |
| out_par | output | 1 | Output byte is parity |

## Verification
The bench builds the encoder with its default limits: at most t = 10 and an 8-bit field. With these values the longest legal codeword (t = 10, K = 235, N = 255) can be sent, and so can the first illegal lengths on either side (K = 15, K = 236). The 4-bit t port also allows an out-of-range value (t = 11) to be applied. Every block changes the configuration inputs after its first byte. Some blocks are sent with gaps in `in_valid`, and one carries a stray start flag inside the message.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
  localparam logic [SYM_W-1:0] ALPHA = 8'h02;

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} enc_state_t;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] x;
    acc = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rs_gen_rom.sv
module rs_gen_rom
  import rs_enc_pkg::*;
#(
  parameter int MAX_T = 10,
  parameter int TW    = 4
) (
  input  logic [TW-1:0]                   t_sel,
  output logic [2*MAX_T-1:0][SYM_W-1:0]   coef
);
  localparam int NP = 2 * MAX_T;

  function automatic logic [NP-1:0][SYM_W-1:0] gen_poly(input int tt);
    logic [NP:0][SYM_W-1:0] g;
    logic [SYM_W-1:0] root;
    g = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < 2 * tt; i++) begin
      for (int j = NP; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, ALPHA);
    end
    return g[NP-1:0];
  endfunction

  logic [NP-1:0][SYM_W-1:0] rows [0:MAX_T];

  for (genvar tv = 0; tv <= MAX_T; tv++) begin : g_row
    localparam logic [NP-1:0][SYM_W-1:0] ROW = gen_poly(tv);
    assign rows[tv] = ROW;
  end

  always_comb begin
    if (t_sel <= TW'(MAX_T)) coef = rows[t_sel];
    else                     coef = '0;
  end
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int MAX_T = 10,
  parameter int TW    = 4,
  parameter int K_MIN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_en,
  input  logic [TW-1:0]    cfg_t,
  input  logic [SYM_W-1:0] cfg_k,
  input  logic             in_valid,
  input  logic             in_sob,
  output logic             in_ready,
  output logic             accept,
  output logic             start,
  output logic             feed,
  output logic             shift,
  output logic             opens,
  output logic [TW-1:0]    t_act
);
  localparam int SW  = SYM_W + 2;
  localparam int PW  = TW + 1;
  localparam logic [SW-1:0] N_MAX = SW'((1 << SYM_W) - 1);

  enc_state_t       state;
  logic [TW-1:0]    t_q;
  logic [SYM_W-1:0] k_q;
  logic [SYM_W-1:0] msg_cnt;
  logic [PW-1:0]    par_cnt;
  logic [SW-1:0]    n_total;
  logic             cfg_ok;
  logic             last_msg;
  logic             last_par;

  assign n_total = SW'(cfg_k) + SW'({cfg_t, 1'b0});
  assign cfg_ok  = enc_en && (cfg_t != '0) && (cfg_t <= TW'(MAX_T)) &&
                   (cfg_k >= SYM_W'(K_MIN)) && (n_total <= N_MAX);

  assign in_ready = (state != ST_PAR);
  assign accept   = in_valid && in_ready;
  assign opens    = accept && in_sob && (state == ST_IDLE);
  assign start    = opens && cfg_ok;
  assign feed     = start || (accept && (state == ST_MSG));
  assign shift    = (state == ST_PAR);
  assign t_act    = (state == ST_IDLE) ? cfg_t : t_q;
  assign last_msg = (msg_cnt == k_q - 1'b1);
  assign last_par = (par_cnt == PW'({t_q, 1'b0}) - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      t_q     <= '0;
      k_q     <= '0;
      msg_cnt <= '0;
      par_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_MSG;
            t_q     <= cfg_t;
            k_q     <= cfg_k;
            msg_cnt <= SYM_W'(1);
          end
        end
        ST_MSG: begin
          if (accept) begin
            if (last_msg) begin
              state   <= ST_PAR;
              par_cnt <= '0;
            end else begin
              msg_cnt <= msg_cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (last_par) state <= ST_IDLE;
          else          par_cnt <= par_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int MAX_T = 10,
  parameter int TW    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          first,
  input  logic                          feed,
  input  logic                          shift,
  input  logic [TW-1:0]                 t_act,
  input  logic [SYM_W-1:0]              din,
  input  logic [2*MAX_T-1:0][SYM_W-1:0] coef,
  output logic [SYM_W-1:0]              par_hi
);
  localparam int NP = 2 * MAX_T;
  localparam int IW = $clog2(NP);

  logic [NP-1:0][SYM_W-1:0] pr;
  logic [NP-1:0][SYM_W-1:0] pr_src;
  logic [NP-1:0][SYM_W-1:0] prod;
  logic [IW-1:0]            hi_idx;
  logic [SYM_W-1:0]         fb;

  always_comb begin
    if (t_act == '0 || t_act > TW'(MAX_T)) hi_idx = '0;
    else hi_idx = IW'({t_act, 1'b0} - 1'b1);
  end

  assign pr_src = first ? '0 : pr;
  assign par_hi = pr[hi_idx];
  assign fb     = din ^ pr_src[hi_idx];

  for (genvar j = 0; j < NP; j++) begin : g_tap
    assign prod[j] = gf_mul(fb, coef[j]);
    always_ff @(posedge clk) begin
      if (rst) begin
        pr[j] <= '0;
      end else if (feed) begin
        if (j == 0) pr[j] <= prod[j];
        else        pr[j] <= pr_src[(j == 0) ? 0 : j-1] ^ prod[j];
      end else if (shift) begin
        if (j == 0) pr[j] <= '0;
        else        pr[j] <= pr[(j == 0) ? 0 : j-1];
      end
    end
  end
endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
  import rs_enc_pkg::*;
#(
  parameter int MAX_T = 10,
  parameter int K_MIN = 16,
  parameter int TW    = $clog2(MAX_T + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_en,
  input  logic [TW-1:0]    cfg_t,
  input  logic [SYM_W-1:0] cfg_k,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_sob,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_sob,
  output logic             out_par
);
  localparam int NP = 2 * MAX_T;

  logic                     accept, start, feed, shift, opens;
  logic [TW-1:0]            t_act;
  logic [NP-1:0][SYM_W-1:0] rom_coef;
  logic [NP-1:0][SYM_W-1:0] coef_q;
  logic [NP-1:0][SYM_W-1:0] coef_use;
  logic [SYM_W-1:0]         par_hi;

  rs_enc_ctrl #(.MAX_T(MAX_T), .TW(TW), .K_MIN(K_MIN)) u_ctrl (
    .clk(clk), .rst(rst), .enc_en(enc_en), .cfg_t(cfg_t), .cfg_k(cfg_k),
    .in_valid(in_valid), .in_sob(in_sob), .in_ready(in_ready),
    .accept(accept), .start(start), .feed(feed), .shift(shift),
    .opens(opens), .t_act(t_act)
  );

  rs_gen_rom #(.MAX_T(MAX_T), .TW(TW)) u_rom (
    .t_sel(cfg_t), .coef(rom_coef)
  );

  assign coef_use = start ? rom_coef : coef_q;

  always_ff @(posedge clk) begin
    if (rst)        coef_q <= '0;
    else if (start) coef_q <= rom_coef;
  end

  rs_parity_lfsr #(.MAX_T(MAX_T), .TW(TW)) u_lfsr (
    .clk(clk), .rst(rst), .first(start), .feed(feed), .shift(shift),
    .t_act(t_act), .din(in_data), .coef(coef_use), .par_hi(par_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sob   <= 1'b0;
      out_par   <= 1'b0;
    end else begin
      out_valid <= accept || shift;
      out_data  <= shift ? par_hi : in_data;
      out_sob   <= opens;
      out_par   <= shift;
    end
  end
endmodule

// File: rtl/rs_enc_checker.sv
module rs_enc_checker #(
  parameter int MAX_T = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sob,
  input logic       out_par
);
  logic       rst_d;
  logic [5:0] run_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)          run_q <= '0;
    else if (out_par) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R1: outputs idle right after reset
  always_ff @(posedge clk) begin
    if (rst_d) a_r1_reset_idle : assert (!out_valid && in_ready);
  end

  // R5: parity run never exceeds 2*MAX_T
  always_ff @(posedge clk) begin
    if (!rst) a_r5_run_bounded : assert (run_q <= 6'(2 * MAX_T));
  end

  a_r3_passthru : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !out_par && out_data == $past(in_data)));

  a_r6_stall_is_parity : assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (out_valid && out_par));

  a_r10_sob_on_data : assert property (@(posedge clk) disable iff (rst)
    out_sob |-> (out_valid && !out_par));

  a_r5_even_run : assert property (@(posedge clk) disable iff (rst)
    $fell(out_par) |-> (run_q != 6'd0 && !run_q[0]));
endmodule

bind rs_stream_encoder rs_enc_checker #(.MAX_T(MAX_T)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .out_sob(out_sob), .out_par(out_par)
);

// File: tb/rs_stream_encoder_test.sv
`timescale 1ns/1ps
module rs_stream_encoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_en = 1'b0;
  logic [3:0] cfg_t = '0;
  logic [7:0] cfg_k = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sob = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sob;
  logic       out_par;

  always #2 clk = ~clk;

  rs_stream_encoder uut (
    .clk(clk), .rst(rst), .enc_en(enc_en), .cfg_t(cfg_t), .cfg_k(cfg_k),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sob(in_sob), .out_valid(out_valid), .out_data(out_data),
    .out_sob(out_sob), .out_par(out_par)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // vector fields: {en, t[3:0], k[7:0], seed[7:0], gap, midsob}
  localparam int NV = 11;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {1'b1, 4'd10, 8'd16,  8'd3,  1'b0, 1'b0},
    {1'b1, 4'd8,  8'd50,  8'd9,  1'b0, 1'b0},
    {1'b1, 4'd1,  8'd20,  8'd21, 1'b0, 1'b0},
    {1'b1, 4'd0,  8'd20,  8'd4,  1'b0, 1'b0},
    {1'b0, 4'd4,  8'd30,  8'd5,  1'b0, 1'b0},
    {1'b1, 4'd10, 8'd235, 8'd77, 1'b0, 1'b0},
    {1'b1, 4'd10, 8'd236, 8'd12, 1'b0, 1'b0},
    {1'b1, 4'd3,  8'd15,  8'd8,  1'b0, 1'b0},
    {1'b1, 4'd11, 8'd20,  8'd6,  1'b0, 1'b0},
    {1'b1, 4'd2,  8'd40,  8'd41, 1'b1, 1'b0},
    {1'b1, 4'd5,  8'd30,  8'd99, 1'b0, 1'b1}
  };

  logic [7:0] cap_d [0:299];
  bit         cap_p [0:299];
  bit         cap_s [0:299];
  int         cap_n = 0;
  int         stall_n = 0;
  bit         mon_on = 1'b0;

  logic [7:0] exp_d [0:299];
  bit         exp_p [0:299];
  bit         exp_s [0:299];
  int         exp_n;

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid && cap_n < 300) begin
        cap_d[cap_n] = out_data;
        cap_p[cap_n] = out_par;
        cap_s[cap_n] = out_sob;
        cap_n++;
      end
      if (!in_ready) stall_n++;
    end
  end

  function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) if (b[i]) w = w ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (w[i]) w = w ^ (16'h11D << (i - 8));
    return w[7:0];
  endfunction

  function automatic logic [7:0] msg_byte(input int seed, input int i);
    return 8'((seed * 37 + i * 29 + i * i * 3) ^ (i >> 2));
  endfunction

  function automatic bit enc_ok(input bit en, input int t, input int k);
    return en && t >= 1 && t <= 10 && k >= 16 && (k + 2 * t) <= 255;
  endfunction

  task automatic build_exp(input bit en, input int t, input int k, input int seed);
    logic [7:0] g [0:20];
    logic [7:0] r [0:299];
    logic [7:0] root;
    bit ok;
    ok = enc_ok(en, t, k);
    for (int i = 0; i < 300; i++) begin r[i] = '0; exp_p[i] = 0; exp_s[i] = 0; end
    for (int i = 0; i < k; i++) begin r[i] = msg_byte(seed, i); exp_d[i] = r[i]; end
    exp_s[0] = 1;
    exp_n = k;
    if (ok) begin
      for (int j = 0; j <= 20; j++) g[j] = '0;
      g[0] = 8'h01;
      root = 8'h01;
      for (int i = 0; i < 2 * t; i++) begin
        for (int j = 2 * t; j >= 1; j--) g[j] = g[j-1] ^ mul8(g[j], root);
        g[0] = mul8(g[0], root);
        root = mul8(root, 8'h02);
      end
      for (int i = 0; i < k; i++) begin
        logic [7:0] c;
        c = r[i];
        for (int j = 1; j <= 2 * t; j++) r[i+j] = r[i+j] ^ mul8(c, g[2*t-j]);
      end
      for (int j = 0; j < 2 * t; j++) begin
        exp_d[k+j] = r[k+j];
        exp_p[k+j] = 1;
      end
      exp_n = k + 2 * t;
    end
  endtask

  task automatic drive_block(input bit en, input int t, input int k, input int seed,
                             input bit gap, input bit mid);
    int i = 0;
    int cyc = 0;
    @(negedge clk);
    enc_en = en; cfg_t = 4'(t); cfg_k = 8'(k);
    while (i < k) begin
      @(negedge clk);
      if (gap && (cyc % 3 == 1)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = msg_byte(seed, i);
        in_sob   = (i == 0) || (mid && i == 3);
        if (i == 1) begin
          // R4: configuration changes after the opening byte
          cfg_t = 4'(t) ^ 4'd1; cfg_k = 8'(k + 3); enc_en = !en;
        end
        if (in_ready) i++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sob = 1'b0;
  endtask

  task automatic run_vec(input bit en, input int t, input int k, input int seed,
                         input bit gap, input bit mid);
    bit ok;
    string tg;
    ok = enc_ok(en, t, k);
    tg = !ok ? (!en ? "R7" : (t == 0 ? "R8" : "R9")) : "R5";
    build_exp(en, t, k, seed);
    cap_n = 0; stall_n = 0; mon_on = 1'b1;
    drive_block(en, t, k, seed, gap, mid);
    repeat (2 * t + 4) @(negedge clk);
    mon_on = 1'b0;
    chk(cap_n == exp_n, {tg, " byte count"}, cap_n, exp_n);
    chk(stall_n == (ok ? 2 * t : 0), "R6 stall cycles", stall_n, ok ? 2 * t : 0);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == exp_d[i], exp_p[i] ? "R2 parity value" : "R3 message byte",
          int'(cap_d[i]), int'(exp_d[i]));
      chk(cap_p[i] == exp_p[i], "R5 parity flag", int'(cap_p[i]), int'(exp_p[i]));
      chk(cap_s[i] == exp_s[i], "R10 sob flag", int'(cap_s[i]), int'(exp_s[i]));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      run_vec(VEC[v][22], int'(VEC[v][21:18]), int'(VEC[v][17:10]),
              int'(VEC[v][9:2]), VEC[v][1], VEC[v][0]);
    end

    // R10: stray bytes outside a block pass through without parity
    enc_en = 1'b1; cfg_t = 4'd4; cfg_k = 8'd20;
    cap_n = 0; stall_n = 0; mon_on = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sob = 1'b0; in_data = 8'(8'hA0 + i);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (12) @(negedge clk);
    mon_on = 1'b0;
    chk(cap_n == 3, "R10 stray count", cap_n, 3);
    chk(stall_n == 0, "R10 stray stall", stall_n, 0);
    for (int i = 0; i < 3 && i < cap_n; i++) begin
      chk(cap_d[i] == 8'(8'hA0 + i) && !cap_p[i] && !cap_s[i], "R10 stray byte",
          int'(cap_d[i]), 8'hA0 + i);
    end

    // R1: reset in the middle of a parity run
    drive_block(1'b1, 10, 16, 55, 1'b0, 1'b0);
    chk(in_ready == 1'b0, "R6 stall before reset", int'(in_ready), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 mid-parity out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 mid-parity in_ready", int'(in_ready), 1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 stays idle", int'(out_valid), 0);

    // block after reset encodes normally
    run_vec(1'b1, 6, 24, 17, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule